// File: doc/BRIEF.md
# NAND Bus Command/Address Adapter

This block connects a plain 32-bit host access port to an 8-bit asynchronous NAND flash bus. The host chooses what each access means through its address: one address bit marks the access as a command, another marks it as an address. With neither set, the access carries data. Every host access is turned into one, two or four byte cycles on the flash side, sent least significant byte first. During each byte cycle the block drives the latch-enable lines, the chip enables, the write strobe and the read strobe, and moves data between the host word and the 8-bit flash data lanes.

Each byte cycle has three phases: setup, strobe-low and hold. The length of each phase is set in clock cycles by configuration inputs. A configurable address mask picks a second chip enable for packages that hold two dies. The shared wire-AND ready/busy line is synchronised and shown to the host as a status bit. The host port accepts a request when it is not busy. It then holds busy until the last byte cycle has finished, and marks the end with a one-cycle acknowledge.

Top module: `nand_bus_adapter`

## Requirements
- R1: Host address bit 4 set drives the command latch line (`nand_cle`) high. Host address bit 3 set, with bit 4 clear, drives the address latch line (`nand_ale`) high. With both bits clear, both lines stay low.
- R2: The command and address latch lines are never high together. When host address bits 3 and 4 are both set, the command latch wins.
- R3: When `host_addr & cfg_cs_mask` is non-zero, the access uses the second die: `nand_ce_n` = 2'b01. Otherwise it uses the first die: `nand_ce_n` = 2'b10. A zero mask always selects the first die.
- R4: Host address bits 1:0 have no effect on the flash bus. They change neither the latch lines, the chip enable nor the number of byte cycles.
- R5: `host_size` sets the number of byte cycles per access: 2'b00 gives one, 2'b01 gives two, and 2'b10 or 2'b11 gives four.
- R6: A write sends `host_wdata` bits 7:0 first, then bits 15:8, and so on. `nand_dq_oe` is high whenever the write strobe is low.
- R7: A read places the byte captured in byte cycle k into bits 8k+7:8k of `host_rdata`. Bytes beyond the access size read as zero. `host_rdata` is valid from the acknowledge onward.
- R8: An access is accepted when `host_req` is high and `host_busy` is low. `host_busy` rises on the following clock edge and stays high until the last byte cycle ends. `host_ack` is high for exactly one cycle, in the cycle in which `host_busy` has just fallen.
- R9: The latch lines and the chip enables hold their values from the start of setup to the end of hold for every byte cycle of an access. While the adapter is idle, both chip enables and both strobes are high and both latch lines are low.
- R10: For an access, the first strobe falls `cfg_setup` cycles after `host_busy` rises. A strobe stays low for `cfg_strobe` cycles. The strobe rises `cfg_hold + cfg_setup` cycles before the next strobe falls. After the last strobe rises, `host_busy` falls `cfg_hold` cycles later. A configured value of 0 acts as 1. The two strobes are never low together.
- R11: `host_flash_ready` follows `nand_wait` (1 = ready, 0 = busy) with two cycles of delay, whether or not an access is running.
- R12: After reset, `host_busy`, `host_ack`, `nand_cle`, `nand_ale` and `nand_dq_oe` are low, `nand_ce_n` is 2'b11, and both strobes are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | Access request |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | AW | Host byte address; bits 4 and 3 select command and address modes |
| host_size | input | 2 | Access width: 0 = byte, 1 = half word, 2 or 3 = word |
| host_wdata | input | DW | Write data |
| host_busy | output | 1 | Access in progress |
| host_ack | output | 1 | One-cycle pulse marking the end of an access |
| host_rdata | output | DW | Assembled read data |
| host_flash_ready | output | 1 | Synchronised ready/busy status, 1 = ready |
| cfg_setup | input | CW | Setup length in cycles |
| cfg_strobe | input | CW | Strobe-low length in cycles |
| cfg_hold | input | CW | Hold length in cycles |
| cfg_cs_mask | input | AW | Address mask that selects the second die |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_ce_n | output | 2 | Chip enables, active low, one per die |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_o | output | 8 | Flash data out |
| nand_dq_oe | output | 1 | Data output enable |
| nand_dq_i | input | 8 | Flash data in |
| nand_wait | input | 1 | Wire-AND ready/busy line |

## Verification
Two functions can fall in the same cycle. Status reporting on the ready line can change while a multi-byte transfer is sending strobes. The two latch-select bits can also arrive together in one request. The bench toggles `nand_wait` in the middle of a word access with long phases. It checks that `host_flash_ready` follows exactly two cycles later while `host_busy` is still high, and that the transfer's bytes and timing are unchanged. Requests with both latch bits set are judged by the latch levels recorded at each strobe edge: the command latch is high and the address latch is low.

// File: rtl/nand_bus_pkg.sv
package nand_bus_pkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_STROBE = 2'd2,
    PH_HOLD   = 2'd3
  } phase_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } size_e;

endpackage

// File: rtl/nand_phase_timer.sv
module nand_phase_timer
  import nand_bus_pkg::*;
#(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          more,
  input  logic [CW-1:0] setup_len,
  input  logic [CW-1:0] strobe_len,
  input  logic [CW-1:0] hold_len,
  output phase_e        phase,
  output phase_e        phase_nxt,
  output logic          strobe_end,
  output logic          byte_end
);

  logic [CW-1:0] cnt, cnt_nxt;

  // A length of zero behaves as one cycle
  function automatic logic [CW-1:0] first_count(input logic [CW-1:0] len);
    return (len == '0) ? '0 : len - 1'b1;
  endfunction

  assign strobe_end = (phase == PH_STROBE) && (cnt == '0);
  assign byte_end   = (phase == PH_HOLD) && (cnt == '0);

  always_comb begin
    phase_nxt = phase;
    cnt_nxt   = (cnt != '0) ? cnt - 1'b1 : cnt;
    unique case (phase)
      PH_IDLE: if (start) begin
        phase_nxt = PH_SETUP;
        cnt_nxt   = first_count(setup_len);
      end
      PH_SETUP: if (cnt == '0) begin
        phase_nxt = PH_STROBE;
        cnt_nxt   = first_count(strobe_len);
      end
      PH_STROBE: if (cnt == '0) begin
        phase_nxt = PH_HOLD;
        cnt_nxt   = first_count(hold_len);
      end
      PH_HOLD: if (cnt == '0) begin
        phase_nxt = more ? PH_SETUP : PH_IDLE;
        cnt_nxt   = more ? first_count(setup_len) : '0;
      end
      default: phase_nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_IDLE;
      cnt   <= '0;
    end else begin
      phase <= phase_nxt;
      cnt   <= cnt_nxt;
    end
  end

  AST_STROBE_AFTER_SETUP: assert property (@(posedge clk) disable iff (rst)
    $rose(phase == PH_STROBE) |-> $past(phase) == PH_SETUP); // R10

  AST_HOLD_AFTER_STROBE: assert property (@(posedge clk) disable iff (rst)
    $rose(phase == PH_HOLD) |-> $past(phase) == PH_STROBE); // R10

endmodule

// File: rtl/nand_lane_seq.sv
module nand_lane_seq
  import nand_bus_pkg::*;
#(
  parameter int BYTES = 4,
  parameter int LW    = $clog2(BYTES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [1:0]    size,
  input  logic          advance,
  output logic [LW-1:0] lane,
  output logic          last
);

  logic [LW-1:0] last_idx;

  assign last = (lane == last_idx);

  always_ff @(posedge clk) begin
    if (rst) begin
      lane     <= '0;
      last_idx <= '0;
    end else if (load) begin
      lane <= '0;
      unique case (size)
        SZ_BYTE: last_idx <= '0;
        SZ_HALF: last_idx <= LW'(1);
        default: last_idx <= LW'(BYTES - 1);
      endcase
    end else if (advance && !last) begin
      lane <= lane + 1'b1;
    end
  end

  AST_LANE_BOUND: assert property (@(posedge clk) disable iff (rst)
    lane <= last_idx); // R5

endmodule

// File: rtl/nand_bus_adapter.sv
module nand_bus_adapter
  import nand_bus_pkg::*;
#(
  parameter int AW      = 16,
  parameter int DW      = 32,
  parameter int CW      = 4,
  parameter int CLE_BIT = 4,
  parameter int ALE_BIT = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          host_req,
  input  logic          host_we,
  input  logic [AW-1:0] host_addr,
  input  logic [1:0]    host_size,
  input  logic [DW-1:0] host_wdata,
  output logic          host_busy,
  output logic          host_ack,
  output logic [DW-1:0] host_rdata,
  output logic          host_flash_ready,
  input  logic [CW-1:0] cfg_setup,
  input  logic [CW-1:0] cfg_strobe,
  input  logic [CW-1:0] cfg_hold,
  input  logic [AW-1:0] cfg_cs_mask,
  output logic          nand_cle,
  output logic          nand_ale,
  output logic [1:0]    nand_ce_n,
  output logic          nand_we_n,
  output logic          nand_re_n,
  output logic [7:0]    nand_dq_o,
  output logic          nand_dq_oe,
  input  logic [7:0]    nand_dq_i,
  input  logic          nand_wait
);

  localparam int BYTES = DW / 8;
  localparam int LW    = $clog2(BYTES);

  phase_e        phase, phase_nxt;
  logic          strobe_end, byte_end;
  logic [LW-1:0] lane;
  logic          last;
  logic          accept;
  logic          wr_q;
  logic [DW-1:0] wbuf, rbuf;
  logic [1:0]    wait_sync;

  assign accept = host_req && !host_busy;

  nand_phase_timer #(.CW(CW)) u_timer (
    .clk        (clk),
    .rst        (rst),
    .start      (accept),
    .more       (!last),
    .setup_len  (cfg_setup),
    .strobe_len (cfg_strobe),
    .hold_len   (cfg_hold),
    .phase      (phase),
    .phase_nxt  (phase_nxt),
    .strobe_end (strobe_end),
    .byte_end   (byte_end)
  );

  nand_lane_seq #(.BYTES(BYTES), .LW(LW)) u_lanes (
    .clk     (clk),
    .rst     (rst),
    .load    (accept),
    .size    (host_size),
    .advance (byte_end),
    .lane    (lane),
    .last    (last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      host_busy  <= 1'b0;
      host_ack   <= 1'b0;
      host_rdata <= '0;
      nand_cle   <= 1'b0;
      nand_ale   <= 1'b0;
      nand_ce_n  <= 2'b11;
      nand_we_n  <= 1'b1;
      nand_re_n  <= 1'b1;
      nand_dq_o  <= '0;
      nand_dq_oe <= 1'b0;
      wr_q       <= 1'b0;
      wbuf       <= '0;
      rbuf       <= '0;
    end else begin
      host_ack  <= 1'b0;
      nand_we_n <= !((phase_nxt == PH_STROBE) && wr_q);
      nand_re_n <= !((phase_nxt == PH_STROBE) && !wr_q);
      if (accept) begin
        host_busy  <= 1'b1;
        wr_q       <= host_we;
        nand_cle   <= host_addr[CLE_BIT];
        nand_ale   <= host_addr[ALE_BIT] && !host_addr[CLE_BIT];
        nand_ce_n  <= (|(host_addr & cfg_cs_mask)) ? 2'b01 : 2'b10;
        nand_dq_o  <= host_wdata[7:0];
        wbuf       <= host_wdata >> 8;
        nand_dq_oe <= host_we;
        rbuf       <= '0;
      end
      if (strobe_end && !wr_q)
        rbuf[{lane, 3'b000} +: 8] <= nand_dq_i;
      if (byte_end) begin
        if (last) begin
          host_busy  <= 1'b0;
          host_ack   <= 1'b1;
          host_rdata <= rbuf;
          nand_cle   <= 1'b0;
          nand_ale   <= 1'b0;
          nand_ce_n  <= 2'b11;
          nand_dq_oe <= 1'b0;
        end else begin
          nand_dq_o <= wbuf[7:0];
          wbuf      <= wbuf >> 8;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wait_sync <= 2'b00;
    end else begin
      wait_sync <= {wait_sync[0], nand_wait};
    end
  end
  assign host_flash_ready = wait_sync[1];

  AST_LATCH_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(nand_cle && nand_ale)); // R2

  AST_SINGLE_DIE: assert property (@(posedge clk) disable iff (rst)
    $countones(~nand_ce_n) <= 1); // R3

  AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(!nand_we_n && !nand_re_n)); // R10

  AST_WRITE_DRIVES_BUS: assert property (@(posedge clk) disable iff (rst)
    !nand_we_n |-> nand_dq_oe); // R6

  AST_ACK_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst)
    host_ack |-> (!host_busy && $past(host_busy))); // R8

  AST_CTRL_STABLE: assert property (@(posedge clk) disable iff (rst)
    (host_busy && $past(host_busy)) |->
      ($stable(nand_cle) && $stable(nand_ale) && $stable(nand_ce_n))); // R9

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !host_busy |-> (nand_we_n && nand_re_n && nand_ce_n == 2'b11)); // R9

endmodule

// File: tb/nand_bus_adapter_test.sv
module nand_bus_adapter_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_req = 1'b0;
  logic        host_we = 1'b0;
  logic [15:0] host_addr = '0;
  logic [1:0]  host_size = '0;
  logic [31:0] host_wdata = '0;
  logic        host_busy, host_ack, host_flash_ready;
  logic [31:0] host_rdata;
  logic [3:0]  cfg_setup = 4'd2, cfg_strobe = 4'd3, cfg_hold = 4'd1;
  logic [15:0] cfg_cs_mask = '0;
  logic        nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
  logic [1:0]  nand_ce_n;
  logic [7:0]  nand_dq_o;
  logic [7:0]  nand_dq_i = 8'h00;
  logic        nand_wait = 1'b0;

  always #10 clk = ~clk;

  nand_bus_adapter uut (
    .clk(clk), .rst(rst), .host_req(host_req), .host_we(host_we),
    .host_addr(host_addr), .host_size(host_size), .host_wdata(host_wdata),
    .host_busy(host_busy), .host_ack(host_ack), .host_rdata(host_rdata),
    .host_flash_ready(host_flash_ready), .cfg_setup(cfg_setup),
    .cfg_strobe(cfg_strobe), .cfg_hold(cfg_hold), .cfg_cs_mask(cfg_cs_mask),
    .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_ce_n(nand_ce_n),
    .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_dq_o(nand_dq_o),
    .nand_dq_oe(nand_dq_oe), .nand_dq_i(nand_dq_i), .nand_wait(nand_wait)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Bus monitor, sampling away from the active edge
  int         cyc = 0, nb = 0, t_start = 0, t_fall = 0, t_rise = 0;
  int         first_gap = 0, mid_gap = 0, low_w = 0, tail = 0, acks = 0;
  logic [7:0] seen [8];
  logic [7:0] rd_pat [4];
  logic       cle_seen, ale_seen, ctrl_bad;
  logic [1:0] ce_seen;
  logic       pbusy = 1'b0, pstrb = 1'b0;

  always @(negedge clk) begin
    logic strb;
    cyc++;
    strb = !(nand_we_n && nand_re_n);
    if (host_busy && !pbusy) begin
      t_start = cyc; nb = 0; ctrl_bad = 1'b0; acks = 0;
      cle_seen = nand_cle; ale_seen = nand_ale; ce_seen = nand_ce_n;
    end
    if (host_busy && (nand_cle !== cle_seen || nand_ale !== ale_seen || nand_ce_n !== ce_seen))
      ctrl_bad = 1'b1;
    if (strb && !pstrb) begin
      if (nb == 0) first_gap = cyc - t_start;
      else mid_gap = cyc - t_rise;
      if (nb < 8) seen[nb] = nand_dq_o;
      if (!nand_re_n && nb < 4) nand_dq_i = rd_pat[nb];
      nb++;
      t_fall = cyc;
    end
    if (!strb && pstrb) begin
      low_w = cyc - t_fall;
      t_rise = cyc;
    end
    if (!host_busy && pbusy) tail = cyc - t_rise;
    if (host_ack) acks++;
    pbusy = host_busy;
    pstrb = strb;
  end

  bit timed_out = 1'b0;

  task automatic access(input logic we, input logic [15:0] addr,
                        input logic [1:0] size, input logic [31:0] wdata);
    int guard = 0;
    @(negedge clk);
    host_req = 1'b1; host_we = we; host_addr = addr;
    host_size = size; host_wdata = wdata;
    @(negedge clk);
    host_req = 1'b0;
    while (!host_ack && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
    if (guard >= 2000) timed_out = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R12 busy", host_busy, 0);
    chk("R12 ack", host_ack, 0);
    chk("R12 ce_n", nand_ce_n, 2'b11);
    chk("R12 strobes", {nand_we_n, nand_re_n}, 2'b11);
    chk("R12 latches/oe", {nand_cle, nand_ale, nand_dq_oe}, 3'b000);
  endtask

  task automatic t_write_word;
    cfg_setup = 4'd2; cfg_strobe = 4'd3; cfg_hold = 4'd1;
    access(1'b1, 16'h0100, 2'd2, 32'hA1B2C3D4);
    chk("R5 word byte count", nb, 4);
    chk("R6 byte0", seen[0], 8'hD4);
    chk("R6 byte1", seen[1], 8'hC3);
    chk("R6 byte2", seen[2], 8'hB2);
    chk("R6 byte3", seen[3], 8'hA1);
    chk("R1 data mode latches", {cle_seen, ale_seen}, 2'b00);
    chk("R10 setup", first_gap, 2);
    chk("R10 strobe width", low_w, 3);
    chk("R10 hold+setup gap", mid_gap, 3);
    chk("R10 tail hold", tail, 1);
    chk("R9 ctrl stable", ctrl_bad, 0);
    chk("R8 single ack", acks, 1);
    chk("R9 idle ce_n", nand_ce_n, 2'b11);
    chk("R9 idle latches", {nand_cle, nand_ale}, 2'b00);
  endtask

  task automatic t_latches;
    access(1'b1, 16'h0010, 2'd0, 32'h000000FF);
    chk("R1 cmd latch", {cle_seen, ale_seen}, 2'b10);
    chk("R1 cmd byte", seen[0], 8'hFF);
    chk("R5 byte count", nb, 1);
    access(1'b1, 16'h0008, 2'd0, 32'h00000033);
    chk("R1 addr latch", {cle_seen, ale_seen}, 2'b01);
    access(1'b1, 16'h0018, 2'd0, 32'h00000044);
    chk("R2 both bits cmd wins", {cle_seen, ale_seen}, 2'b10);
  endtask

  task automatic t_lowbits;
    access(1'b1, 16'h000B, 2'd1, 32'h00007788);
    chk("R4 latches ignore low bits", {cle_seen, ale_seen}, 2'b01);
    chk("R4 count ignores low bits", nb, 2);
    chk("R4 ce ignores low bits", ce_seen, 2'b10);
    chk("R5 half bytes", {seen[0], seen[1]}, 16'h8877);
  endtask

  task automatic t_read;
    rd_pat[0] = 8'h11; rd_pat[1] = 8'h22; rd_pat[2] = 8'h33; rd_pat[3] = 8'h44;
    access(1'b0, 16'h0000, 2'd3, 32'hFFFFFFFF);
    chk("R7 word read", host_rdata, 32'h44332211);
    chk("R5 read count", nb, 4);
    rd_pat[0] = 8'h5A; rd_pat[1] = 8'hA5;
    access(1'b0, 16'h0000, 2'd1, 32'h0);
    chk("R7 half read upper zero", host_rdata, 32'h0000A55A);
  endtask

  task automatic t_chipsel;
    cfg_cs_mask = 16'h1000;
    access(1'b1, 16'h1000, 2'd0, 32'h1);
    chk("R3 second die", ce_seen, 2'b01);
    access(1'b1, 16'h0000, 2'd0, 32'h1);
    chk("R3 first die", ce_seen, 2'b10);
    cfg_cs_mask = 16'h0000;
    access(1'b1, 16'h1000, 2'd0, 32'h1);
    chk("R3 zero mask", ce_seen, 2'b10);
  endtask

  task automatic t_zero_timing;
    cfg_setup = 4'd0; cfg_strobe = 4'd0; cfg_hold = 4'd0;
    access(1'b1, 16'h0000, 2'd1, 32'h0000BEEF);
    chk("R10 zero setup", first_gap, 1);
    chk("R10 zero strobe", low_w, 1);
    chk("R10 zero gap", mid_gap, 2);
    chk("R10 zero tail", tail, 1);
    chk("R6 zero timing data", {seen[1], seen[0]}, 16'hBEEF);
  endtask

  task automatic t_ready_during_access;
    cfg_setup = 4'd5; cfg_strobe = 4'd5; cfg_hold = 4'd5;
    nand_wait = 1'b0;
    repeat (3) @(negedge clk);
    chk("R11 busy reported", host_flash_ready, 0);
    fork
      access(1'b1, 16'h0000, 2'd2, 32'h0D0C0B0A);
      begin
        repeat (6) @(negedge clk);
        nand_wait = 1'b1;
        @(negedge clk);
        chk("R11 one cycle not yet", host_flash_ready, 0);
        @(negedge clk);
        chk("R11 ready after two", host_flash_ready, 1);
        chk("R11 during access", host_busy, 1);
      end
    join
    chk("R6 bytes under ready change", {seen[3], seen[2], seen[1], seen[0]}, 32'h0D0C0B0A);
    chk("R10 long strobe", low_w, 5);
    nand_wait = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R11 busy again", host_flash_ready, 0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    timed_out = 1'b1;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_write_word();
    t_latches();
    t_lowbits();
    t_read();
    t_chipsel();
    t_zero_timing();
    t_ready_during_access();
    if (timed_out) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=1 expected=0");
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    if (timed_out && !rst && cyc > 100000) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule